// File: doc/BRIEF.md
# Multi-Source Reset Controller with Main-Clock Fallback

The controller merges four reset requests into one system reset. The requests are an asynchronous external pin, a watchdog overflow pulse, a low-voltage trip and a clock-monitor stop event. It records which internal source caused each reset in a small cause register. Software can read that register at any time and clear its bits by writing ones. A second reset output drives the low-voltage detector's own configuration registers. That output ignores the low-voltage source, so a brown-out does not wipe out the detector's setup.

The whole block runs on the internal oscillator clock, so it keeps working when the main oscillator is dead. After the system reset is released, the block counts a stabilization interval before it reports that the main clock is ready. A watchdog overflow inside that interval is taken to mean the main oscillator has failed. The block then latches an emergency state. In that state it selects the internal oscillator as the CPU clock and raises a flag telling the system that peripheral access is restricted. Only interrupt, port, watchdog and one timer peripheral may be used, and serial interfaces running on an external clock may not. Only a pin reset or a low-voltage reset leaves the emergency state.

Top module: `rst_ctrl_top`

## Requirements
- R1: Driving `ext_rst_n` low forces `sys_rst_n` and `lvd_cfg_rst_n` low at once, with no clock needed. After the pin rises, both outputs go high at the (SYNC_STAGES+HOLD_CYCLES)-th rising edge, which is the 6th by default, provided no other request arrives.
- R2: A high `wdt_ovf`, `clkmon_stop` or `lvd_trip` sampled at a rising edge drives `sys_rst_n` low after that edge. `sys_rst_n` goes high again at the HOLD_CYCLES-th (4th) following edge at which no request is sampled.
- R3: `lvd_cfg_rst_n` obeys R1 and R2 for every source except `lvd_trip`, which has no effect on it.
- R4: `reg_rdata` holds the cause flags. Bit 0 is the watchdog, bit 1 is the clock-monitor stop and bit 2 is the low-voltage trip. A flag is set after the edge at which its source is sampled high. Sources sampled together set their flags together. Flags survive internal resets.
- R5: While `ext_rst_n` is low, all three cause flags read 0.
- R6: A cycle with `reg_wr` high clears each flag whose `reg_wdata` bit is 1. Bits written as 0 have no effect. When a flag is cleared and set in the same cycle, it ends up set.
- R7: `clk_ready` is low whenever `sys_rst_n` is low. It rises at the STAB_CYCLES-th rising edge (256 by default) after the edge at which `sys_rst_n` rose.
- R8: A `wdt_ovf` sampled while `sys_rst_n` is high and `clk_ready` is low sets `emerg_mode` after that edge. A `wdt_ovf` at any other time leaves `emerg_mode` unchanged.
- R9: `cpu_clk_int` (1 selects the internal oscillator) and `periph_lock` are high exactly when `emerg_mode` is high.
- R10: Once set, `emerg_mode` stays set through watchdog and clock-monitor resets. It is cleared only by `ext_rst_n` low or by a sampled `lvd_trip`, and a sampled `lvd_trip` wins over a simultaneous set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_int | input | 1 | Internal oscillator clock; clocks the whole block |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| wdt_ovf | input | 1 | Watchdog overflow request, synchronous |
| clkmon_stop | input | 1 | Clock-monitor oscillation-stop request, synchronous |
| lvd_trip | input | 1 | Low-voltage detector reset request, synchronous |
| reg_wr | input | 1 | Write strobe for the cause register |
| reg_wdata | input | 3 | Write-one-to-clear mask for the cause flags |
| reg_rdata | output | 3 | Cause flags {low-voltage, clock-stop, watchdog} |
| sys_rst_n | output | 1 | System reset, active low |
| lvd_cfg_rst_n | output | 1 | Reset for the detector's configuration registers, active low |
| clk_ready | output | 1 | Main-clock stabilization interval has elapsed |
| emerg_mode | output | 1 | Main-clock failure detected; emergency operation |
| cpu_clk_int | output | 1 | CPU clock source select, 1 = internal oscillator |
| periph_lock | output | 1 | Peripheral access restricted to the emergency subset |

## Verification
Every registered result of this block appears one edge after the request that causes it: a flag, an emergency set or clear, and the assertion of either reset. Release follows a fixed count of quiet edges: 4 after the last internal request and 6 after the pin rises. Ready follows exactly 256 edges after release. The reference model advances on each rising edge using the inputs held since the previous falling edge. The outputs are compared one time unit after the edge, so every check lands in the cycle the count predicts. Directed checks at falling edges confirm the stated outcomes of each scenario.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

  localparam int FLAG_W  = 3;
  localparam int FLG_WDT = 0;
  localparam int FLG_CLK = 1;
  localparam int FLG_LVD = 2;

  // Sources that the detector-configuration reset must not follow.
  localparam logic [FLAG_W-1:0] CFG_SPARE_MASK = 3'b100;

  typedef enum logic {
    ST_WAIT = 1'b0,
    ST_RUN  = 1'b1
  } stab_e;

  // Place each internal source at its cause-flag position.
  function automatic logic [FLAG_W-1:0] src_vector(input logic wdt,
                                                   input logic clm,
                                                   input logic lvd);
    logic [FLAG_W-1:0] v;
    v          = '0;
    v[FLG_WDT] = wdt;
    v[FLG_CLK] = clm;
    v[FLG_LVD] = lvd;
    return v;
  endfunction

  // Write-one-to-clear, with hardware set taking priority.
  function automatic logic [FLAG_W-1:0] flags_next(input logic [FLAG_W-1:0] cur,
                                                   input logic [FLAG_W-1:0] set,
                                                   input logic [FLAG_W-1:0] clr);
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/rstc_sync2.sv
module rstc_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic released
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sh_q <= '0;
        else         sh_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sh_q <= '0;
        else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign released = sh_q[STAGES-1];
endmodule

// File: rtl/rstc_stretch.sv
module rstc_stretch #(
  parameter int HOLD = 4
) (
  input  logic clk,
  input  logic arst_n,
  input  logic req,
  output logic rst_n_o
);
  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] HOLD_V = CW'(HOLD);
  localparam logic [CW-1:0] ONE_V  = CW'(1);

  logic [CW-1:0] cnt_q;
  logic          act_q;
  logic          keep;

  // Stay asserted while requested or while more than one hold cycle remains.
  assign keep = req || (cnt_q > ONE_V);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q <= HOLD_V;
      act_q <= 1'b1;
    end else begin
      act_q <= keep;
      if (req)                cnt_q <= HOLD_V;
      else if (cnt_q != '0)   cnt_q <= cnt_q - ONE_V;
    end
  end

  assign rst_n_o = ~act_q;
endmodule

// File: rtl/rstc_cause.sv
module rstc_cause
  import rstc_pkg::*;
(
  input  logic              clk,
  input  logic              arst_n,
  input  logic [FLAG_W-1:0] set_vec,
  input  logic              wr,
  input  logic [FLAG_W-1:0] wmask,
  output logic [FLAG_W-1:0] flags
);
  logic [FLAG_W-1:0] flags_q;
  logic [FLAG_W-1:0] clr_vec;

  assign clr_vec = wr ? wmask : '0;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) flags_q <= '0;
    else         flags_q <= flags_next(flags_q, set_vec, clr_vec);
  end

  assign flags = flags_q;
endmodule

// File: rtl/rstc_stab.sv
module rstc_stab
  import rstc_pkg::*;
#(
  parameter int STAB_CYCLES = 256
) (
  input  logic clk,
  input  logic arst_n,
  input  logic rst_act,
  input  logic wdt_ovf,
  input  logic lvd_trip,
  output logic ready_o,
  output logic emerg_o,
  output logic win_wdt_o
);
  localparam int SW = $clog2(STAB_CYCLES + 1);
  localparam logic [SW-1:0] LAST_V = SW'(STAB_CYCLES - 1);
  localparam logic [SW-1:0] ONE_V  = SW'(1);

  stab_e         st_q;
  logic [SW-1:0] scnt_q;
  logic          emerg_q;
  logic          in_win;

  assign in_win    = (st_q == ST_WAIT) && !rst_act;
  assign win_wdt_o = in_win && wdt_ovf;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      st_q   <= ST_WAIT;
      scnt_q <= '0;
    end else if (rst_act) begin
      st_q   <= ST_WAIT;
      scnt_q <= '0;
    end else if (st_q == ST_WAIT) begin
      scnt_q <= scnt_q + ONE_V;
      if (scnt_q == LAST_V) st_q <= ST_RUN;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)        emerg_q <= 1'b0;
    else if (lvd_trip)  emerg_q <= 1'b0;
    else if (win_wdt_o) emerg_q <= 1'b1;
  end

  assign ready_o = (st_q == ST_RUN) && !rst_act;
  assign emerg_o = emerg_q;
endmodule

// File: rtl/rst_ctrl_top.sv
module rst_ctrl_top
  import rstc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 4,
  parameter int STAB_CYCLES = 256
) (
  input  logic              clk_int,
  input  logic              ext_rst_n,
  input  logic              wdt_ovf,
  input  logic              clkmon_stop,
  input  logic              lvd_trip,
  input  logic              reg_wr,
  input  logic [FLAG_W-1:0] reg_wdata,
  output logic [FLAG_W-1:0] reg_rdata,
  output logic              sys_rst_n,
  output logic              lvd_cfg_rst_n,
  output logic              clk_ready,
  output logic              emerg_mode,
  output logic              cpu_clk_int,
  output logic              periph_lock
);
  localparam int N_DOM = 2;

  logic              ext_rel;
  logic              ext_req;
  logic [FLAG_W-1:0] src_vec;
  logic [N_DOM-1:0]  dom_req;
  logic [N_DOM-1:0]  dom_rst_n;
  logic              win_wdt;
  logic              emerg;

  rstc_sync2 #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk_int),
    .arst_n   (ext_rst_n),
    .released (ext_rel)
  );

  assign ext_req = ~ext_rel;
  assign src_vec = src_vector(wdt_ovf, clkmon_stop, lvd_trip);

  // Domain 0: system reset; domain 1: detector configuration reset.
  assign dom_req[0] = ext_req | (|src_vec);
  assign dom_req[1] = ext_req | (|(src_vec & ~CFG_SPARE_MASK));

  for (genvar g = 0; g < N_DOM; g++) begin : g_dom
    rstc_stretch #(.HOLD(HOLD_CYCLES)) u_str (
      .clk     (clk_int),
      .arst_n  (ext_rst_n),
      .req     (dom_req[g]),
      .rst_n_o (dom_rst_n[g])
    );
  end

  rstc_cause u_cause (
    .clk     (clk_int),
    .arst_n  (ext_rst_n),
    .set_vec (src_vec),
    .wr      (reg_wr),
    .wmask   (reg_wdata),
    .flags   (reg_rdata)
  );

  rstc_stab #(.STAB_CYCLES(STAB_CYCLES)) u_stab (
    .clk       (clk_int),
    .arst_n    (ext_rst_n),
    .rst_act   (~dom_rst_n[0]),
    .wdt_ovf   (wdt_ovf),
    .lvd_trip  (lvd_trip),
    .ready_o   (clk_ready),
    .emerg_o   (emerg),
    .win_wdt_o (win_wdt)
  );

  assign sys_rst_n     = dom_rst_n[0];
  assign lvd_cfg_rst_n = dom_rst_n[1];
  assign emerg_mode    = emerg;
  assign cpu_clk_int   = emerg;
  assign periph_lock   = emerg;
endmodule

// File: rtl/rstc_checker.sv
module rstc_checker (
  input logic clk,
  input logic ext_rst_n,
  input logic wdt_ovf,
  input logic clkmon_stop,
  input logic lvd_trip,
  input logic reg_wr,
  input logic wmask_wdt,
  input logic flag_wdt,
  input logic sys_rst_n,
  input logic lvd_cfg_rst_n,
  input logic clk_ready,
  input logic emerg_mode,
  input logic ext_req,
  input logic win_wdt
);
  // R1: pin low holds both resets low
  always @(negedge clk) begin
    if (ext_rst_n === 1'b0) begin
      p_ext_async_r1: assert (sys_rst_n === 1'b0 && lvd_cfg_rst_n === 1'b0)
        else $error("pin reset not propagated");
    end
  end

  p_wdt_resets_r2: assert property (@(posedge clk) disable iff (!ext_rst_n)
    wdt_ovf |=> !sys_rst_n);

  p_lvd_spared_r3: assert property (@(posedge clk) disable iff (!ext_rst_n)
    (lvd_trip && lvd_cfg_rst_n && !wdt_ovf && !clkmon_stop && !ext_req) |=> lvd_cfg_rst_n);

  p_flag_set_r4: assert property (@(posedge clk) disable iff (!ext_rst_n)
    wdt_ovf |=> flag_wdt);

  p_w1c_r6: assert property (@(posedge clk) disable iff (!ext_rst_n)
    (reg_wr && wmask_wdt && !wdt_ovf) |=> !flag_wdt);

  p_ready_gated_r7: assert property (@(posedge clk) disable iff (!ext_rst_n)
    clk_ready |-> sys_rst_n);

  p_window_emerg_r8: assert property (@(posedge clk) disable iff (!ext_rst_n)
    (win_wdt && !lvd_trip) |=> emerg_mode);

  p_emerg_sticky_r10: assert property (@(posedge clk) disable iff (!ext_rst_n)
    (emerg_mode && !lvd_trip) |=> emerg_mode);
endmodule

bind rst_ctrl_top rstc_checker u_chk (
  .clk           (clk_int),
  .ext_rst_n     (ext_rst_n),
  .wdt_ovf       (wdt_ovf),
  .clkmon_stop   (clkmon_stop),
  .lvd_trip      (lvd_trip),
  .reg_wr        (reg_wr),
  .wmask_wdt     (reg_wdata[0]),
  .flag_wdt      (reg_rdata[0]),
  .sys_rst_n     (sys_rst_n),
  .lvd_cfg_rst_n (lvd_cfg_rst_n),
  .clk_ready     (clk_ready),
  .emerg_mode    (emerg_mode),
  .ext_req       (ext_req),
  .win_wdt       (win_wdt)
);

// File: tb/sim_rst_ctrl_top.sv
module sim_rst_ctrl_top;
  localparam int CLK_PERIOD = 10;
  localparam int STAB       = 256;
  localparam int HOLD       = 4;
  localparam int SYNC       = 2;
  localparam int WD_LIMIT   = 60000;

  logic       clk = 1'b0;
  logic       ext_rst_n = 1'b0;
  logic       wdt_ovf = 1'b0, clkmon_stop = 1'b0, lvd_trip = 1'b0, reg_wr = 1'b0;
  logic [2:0] reg_wdata = 3'b000;
  logic [2:0] reg_rdata;
  logic       sys_rst_n, lvd_cfg_rst_n, clk_ready, emerg_mode, cpu_clk_int, periph_lock;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_ctrl_top u0 (
    .clk_int(clk), .ext_rst_n(ext_rst_n), .wdt_ovf(wdt_ovf), .clkmon_stop(clkmon_stop),
    .lvd_trip(lvd_trip), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sys_rst_n(sys_rst_n), .lvd_cfg_rst_n(lvd_cfg_rst_n), .clk_ready(clk_ready),
    .emerg_mode(emerg_mode), .cpu_clk_int(cpu_clk_int), .periph_lock(periph_lock)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // Behavioural reference: counters of quiet edges, pin-high edges and wait length.
  int         m_hi = 0, m_ha = HOLD, m_hb = HOLD, m_wait = 0;
  bit         m_rdy = 1'b0, m_em = 1'b0;
  logic [2:0] m_fl = 3'b000;

  always @(posedge clk) begin
    bit act_old, win, ereq;
    logic [2:0] clrv;
    if (!ext_rst_n) begin
      m_hi = 0; m_ha = HOLD; m_hb = HOLD; m_wait = 0; m_rdy = 0; m_em = 0; m_fl = 3'b000;
    end else begin
      act_old = (m_ha > 0);
      win     = !act_old && !m_rdy;
      if (m_hi < 1000) m_hi++;
      ereq = (m_hi <= SYNC);
      clrv = reg_wr ? reg_wdata : 3'b000;
      m_fl = (m_fl & ~clrv) | {lvd_trip, clkmon_stop, wdt_ovf};
      if (lvd_trip) m_em = 0;
      else if (wdt_ovf && win) m_em = 1;
      if (act_old) begin
        m_wait = 0; m_rdy = 0;
      end else if (!m_rdy) begin
        m_wait++;
        if (m_wait == STAB) m_rdy = 1;
      end
      m_ha = (ereq || wdt_ovf || clkmon_stop || lvd_trip) ? HOLD : (m_ha > 0 ? m_ha - 1 : 0);
      m_hb = (ereq || wdt_ovf || clkmon_stop) ? HOLD : (m_hb > 0 ? m_hb - 1 : 0);
    end
    #1;
    if (!done) begin
      chk("R1/R2 sys_rst_n", sys_rst_n, (m_ha == 0));
      chk("R3 lvd_cfg_rst_n", lvd_cfg_rst_n, (m_hb == 0));
      chk("R4 reg_rdata", reg_rdata, m_fl);
      chk("R7 clk_ready", clk_ready, (m_rdy && m_ha == 0));
      chk("R8 emerg_mode", emerg_mode, m_em);
      chk("R9 cpu_clk_int", cpu_clk_int, m_em);
      chk("R9 periph_lock", periph_lock, m_em);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input bit w, input bit c, input bit l);
    @(negedge clk);
    wdt_ovf = w; clkmon_stop = c; lvd_trip = l;
    @(negedge clk);
    wdt_ovf = 0; clkmon_stop = 0; lvd_trip = 0;
  endtask

  task automatic write_clr(input logic [2:0] m);
    @(negedge clk);
    reg_wr = 1; reg_wdata = m;
    @(negedge clk);
    reg_wr = 0; reg_wdata = 3'b000;
  endtask

  initial begin
    step(3);
    chk("R1 reset state sys_rst_n", sys_rst_n, 0);
    chk("R5 flags clear under pin", reg_rdata, 0);
    ext_rst_n = 1;
    step(5);
    chk("R1 still held 5 edges after pin", sys_rst_n, 0);
    step(1);
    chk("R1 released at 6th edge", sys_rst_n, 1);
    step(STAB + 4);
    chk("R7 ready after wait", clk_ready, 1);

    pulse(1, 0, 0);
    chk("R2 wdt reset", sys_rst_n, 0);
    chk("R3 cfg follows wdt", lvd_cfg_rst_n, 0);
    chk("R4 wdt flag", reg_rdata, 3'b001);
    step(STAB + 8);
    chk("R8 no emerg outside window", emerg_mode, 0);

    write_clr(3'b110);
    chk("R6 zero bits no effect", reg_rdata, 3'b001);
    write_clr(3'b001);
    chk("R6 write one clears", reg_rdata, 3'b000);

    pulse(1, 1, 0);
    chk("R4 simultaneous flags", reg_rdata, 3'b011);
    step(STAB + 8);

    pulse(0, 0, 1);
    chk("R3 cfg ignores lvd", lvd_cfg_rst_n, 1);
    chk("R2 lvd resets system", sys_rst_n, 0);
    chk("R4 lvd flag", reg_rdata[2], 1);
    step(STAB + 8);

    write_clr(3'b111);
    @(negedge clk);
    clkmon_stop = 1; reg_wr = 1; reg_wdata = 3'b010;
    @(negedge clk);
    clkmon_stop = 0; reg_wr = 0; reg_wdata = 3'b000;
    chk("R6 set wins over clear", reg_rdata, 3'b010);
    step(STAB + 8);

    // Watchdog inside the stabilization window.
    pulse(0, 1, 0);
    step(8);
    chk("R7 not ready in window", clk_ready, 0);
    pulse(1, 0, 0);
    chk("R8 emerg set in window", emerg_mode, 1);
    chk("R9 internal clock selected", cpu_clk_int, 1);
    chk("R9 peripheral lock", periph_lock, 1);
    step(STAB + 8);
    chk("R10 emerg kept after wait", emerg_mode, 1);
    pulse(0, 1, 0);
    step(STAB + 8);
    chk("R10 emerg survives clock-stop reset", emerg_mode, 1);
    pulse(0, 0, 1);
    chk("R10 lvd clears emerg", emerg_mode, 0);
    step(8);
    pulse(1, 0, 0);
    chk("R8 emerg set again", emerg_mode, 1);
    @(negedge clk);
    ext_rst_n = 0;
    step(2);
    chk("R10 pin clears emerg", emerg_mode, 0);
    chk("R5 pin clears flags", reg_rdata, 0);
    ext_rst_n = 1;
    step(STAB + 10);

    // Long request: reset held throughout, released 4 quiet edges later.
    @(negedge clk);
    clkmon_stop = 1;
    step(10);
    chk("R2 held during long request", sys_rst_n, 0);
    clkmon_stop = 0;
    step(3);
    chk("R2 held 3 quiet edges", sys_rst_n, 0);
    step(1);
    chk("R2 released 4th quiet edge", sys_rst_n, 1);
    step(STAB + 4);
    finish_run();
  end

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL R7 watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule